// File: doc/BRIEF.md
# Flash Page-Range Erase Sequencer

This block turns one host request of the form "erase this address range" into the series of serial-flash commands that the erase needs. It sits between a request port and a byte-level serial master that handles bit timing. For each 4 KiB page in the range it sends four commands in order: write-enable, sector-unprotect with the page address, a second write-enable, and page-erase with the page address. It then issues read-status commands until the device reports that it is idle. After the last page it sends write-disable and returns a one-cycle completion pulse.

Before any command goes out, the block checks the request. The start address and the length must be multiples of 4096. The length must not be zero. The range must end at or below the device size. A request that fails any of these is answered straight away with completion plus error, and the chip select never moves. Busy polling is bounded by a limit that the host sets. If that many status reads in a row report busy, the block stops erasing, sends write-disable and reports an error.

The block controls chip select itself. Select is low for exactly the bytes of one command and high for a programmable number of cycles between commands. Each byte goes to the byte engine through a request/done handshake.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is asserted, and after it, the outputs are: spi_cs_n high, byte_req low, done low, err low, req_ready high.
- R2: A request is rejected if any of these holds: req_addr has a nonzero bit in [11:0], req_len has a nonzero bit in [11:0], req_len is zero, or req_addr+req_len exceeds DEV_BYTES (default 1 MiB). A rejected request gives done and err high in the cycle after it is accepted, and no byte is sent.
- R3: For each page the command frames are, in order: {0x06}, {0x39,A2,A1,A0}, {0x06}, {0x20,A2,A1,A0}. These are followed by one or more status frames {0x05,0x00}.
- R4: The page address bytes A2,A1,A0 are sent most significant byte first. The first page uses req_addr, and each later page adds 4096.
- R5: Every poll is a full two-byte status frame. Only bit 0 of the byte received for the second byte is read, and 1 means busy. The next page starts after the first poll that returns bit 0 clear.
- R6: After the last page goes idle, the block sends the single frame {0x04} and then pulses done with err low.
- R7: If poll_limit status reads in a row for one page return busy, the block sends no more erase frames, sends {0x04}, and pulses done with err high. A limit of 0 acts as 1.
- R8: spi_cs_n is low only while the bytes of one command are being moved. Between frames it is high for at least CS_GAP cycles (default 2).
- R9: byte_tx stays stable while byte_req is high and byte_done has not arrived. byte_req is never high while spi_cs_n is high.
- R10: req_ready is high only while the block is idle. done is a single-cycle pulse, and spi_cs_n is high while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host erase request valid |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 24 | Start byte address of the range |
| req_len | input | 24 | Length of the range in bytes |
| poll_limit | input | 16 | Maximum busy status reads per page |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error qualifier, valid with done |
| spi_cs_n | output | 1 | Active-low flash chip select |
| byte_req | output | 1 | Byte transfer request to the byte engine, held until byte_done |
| byte_tx | output | 8 | Byte to shift out |
| byte_done | input | 1 | Byte engine finished the current byte |
| byte_rx | input | 8 | Byte shifted in during the finished transfer |

## Verification
A wrong command index or page counter shows up at once in the captured byte stream. It appears as a misplaced opcode, a missing second write-enable, or a page address that does not advance by 4096, and it is visible in the first frame that follows the wrong state. A broken poll counter or busy decode shows only once the device holds busy. The bench therefore pairs busy counts just below and at the poll limit, so that the error flag and the number of status frames differ by one frame. Wrong range checks show as select activity, or as a missing error within one cycle of acceptance.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_XFER,
    ST_FINISH
  } seq_state_t;

  typedef enum logic [2:0] {
    CMD_WREN_A,
    CMD_UNPROT,
    CMD_WREN_B,
    CMD_ERASE,
    CMD_STATUS,
    CMD_WRDIS
  } cmd_kind_t;

  localparam logic [7:0] OP_WREN        = 8'h06;
  localparam logic [7:0] OP_WRDIS       = 8'h04;
  localparam logic [7:0] OP_UNPROT      = 8'h39;
  localparam logic [7:0] OP_ERASE       = 8'h20;
  localparam logic [7:0] OP_STATUS      = 8'h05;
  localparam logic [7:0] STAT_BUSY_MASK = 8'h01;

endpackage

// File: rtl/erase_req_check.sv
module erase_req_check #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_LOG2 = 12,
  parameter int DEV_BYTES = 1 << 20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] len,
  output logic              bad
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEV_BYTES);

  logic [ADDR_W:0] end_w;

  always_comb begin
    end_w = {1'b0, addr} + {1'b0, len};
    bad   = (|addr[PAGE_LOG2-1:0]) || (|len[PAGE_LOG2-1:0]) ||
            (len == '0) || (end_w > LIMIT);
  end

endmodule

// File: rtl/erase_cmd_frame.sv
module erase_cmd_frame
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 2
) (
  input  cmd_kind_t         kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        tx_byte,
  output logic              last
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BYTES);

  logic [7:0] addr_byte;

  // idx 1 selects the most significant address byte
  always_comb begin
    addr_byte = '0;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (idx == IDX_W'(ADDR_BYTES - b)) addr_byte = addr[8*b +: 8];
    end
  end

  always_comb begin
    tx_byte = OP_WRDIS;
    last    = 1'b1;
    case (kind)
      CMD_WREN_A, CMD_WREN_B: begin
        tx_byte = OP_WREN;
        last    = 1'b1;
      end
      CMD_UNPROT: begin
        tx_byte = (idx == '0) ? OP_UNPROT : addr_byte;
        last    = (idx == ADDR_LAST);
      end
      CMD_ERASE: begin
        tx_byte = (idx == '0) ? OP_ERASE : addr_byte;
        last    = (idx == ADDR_LAST);
      end
      CMD_STATUS: begin
        tx_byte = (idx == '0) ? OP_STATUS : 8'h00;
        last    = (idx == IDX_W'(1));
      end
      default: begin
        tx_byte = OP_WRDIS;
        last    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/erase_poll_timer.sv
module erase_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             at_limit
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en   = clear | bump;
    cnt_n    = clear ? '0 : ((cnt_q == '1) ? cnt_q : cnt_q + 1'b1);
    at_limit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_LOG2 = 12,
  parameter int DEV_BYTES = 1 << 20,
  parameter int CS_GAP    = 2,
  parameter int POLL_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done,
  output logic              err,
  output logic              spi_cs_n,
  output logic              byte_req,
  output logic [7:0]        byte_tx,
  input  logic              byte_done,
  input  logic [7:0]        byte_rx
);

  localparam int PAGES_W    = ADDR_W - PAGE_LOG2;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
  localparam int GAP_W      = $clog2(CS_GAP + 1);
  localparam logic [ADDR_W-1:0] PAGE_STEP = ADDR_W'(1) << PAGE_LOG2;
  localparam logic [GAP_W-1:0]  GAP_END   = GAP_W'(CS_GAP - 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  seq_state_t         state_q, state_n;
  cmd_kind_t          cmd_q, cmd_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [GAP_W-1:0]   gap_q, gap_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [PAGES_W-1:0] pages_q, pages_n;
  logic               err_q, err_n;
  logic               range_en;

  logic       req_bad;
  logic       frame_last;
  logic [7:0] frame_byte;
  logic       poll_clear, poll_bump, poll_at_limit;
  logic       dev_busy;

  erase_req_check #(
    .ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .DEV_BYTES(DEV_BYTES)
  ) u_check (
    .addr(req_addr), .len(req_len), .bad(req_bad)
  );

  erase_cmd_frame #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_frame (
    .kind(cmd_q), .idx(idx_q), .addr(addr_q),
    .tx_byte(frame_byte), .last(frame_last)
  );

  erase_poll_timer #(
    .CNT_W(POLL_W)
  ) u_poll (
    .clk(clk), .rst_n(rst_core_n), .clear(poll_clear), .bump(poll_bump),
    .limit(poll_limit), .at_limit(poll_at_limit)
  );

  assign dev_busy = |(byte_rx & STAT_BUSY_MASK);

  // next-state logic
  always_comb begin
    state_n    = state_q;
    cmd_n      = cmd_q;
    idx_n      = idx_q;
    gap_n      = gap_q;
    addr_n     = addr_q;
    pages_n    = pages_q;
    err_n      = err_q;
    range_en   = 1'b0;
    poll_clear = 1'b0;
    poll_bump  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_bad) begin
            err_n   = 1'b1;
            state_n = ST_FINISH;
          end else begin
            err_n    = 1'b0;
            range_en = 1'b1;
            addr_n   = req_addr;
            pages_n  = req_len[ADDR_W-1:PAGE_LOG2];
            cmd_n    = CMD_WREN_A;
            idx_n    = '0;
            gap_n    = '0;
            state_n  = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gap_q == GAP_END) begin
          idx_n   = '0;
          state_n = ST_XFER;
        end else begin
          gap_n = gap_q + 1'b1;
        end
      end
      ST_XFER: begin
        if (byte_done) begin
          if (!frame_last) begin
            idx_n = idx_q + 1'b1;
          end else begin
            state_n = ST_GAP;
            gap_n   = '0;
            case (cmd_q)
              CMD_WREN_A: cmd_n = CMD_UNPROT;
              CMD_UNPROT: cmd_n = CMD_WREN_B;
              CMD_WREN_B: cmd_n = CMD_ERASE;
              CMD_ERASE: begin
                cmd_n      = CMD_STATUS;
                poll_clear = 1'b1;
              end
              CMD_STATUS: begin
                if (!dev_busy) begin
                  if (pages_q == PAGES_W'(1)) begin
                    cmd_n = CMD_WRDIS;
                  end else begin
                    range_en = 1'b1;
                    pages_n  = pages_q - 1'b1;
                    addr_n   = addr_q + PAGE_STEP;
                    cmd_n    = CMD_WREN_A;
                  end
                end else begin
                  poll_bump = 1'b1;
                  if (poll_at_limit) begin
                    err_n = 1'b1;
                    cmd_n = CMD_WRDIS;
                  end
                end
              end
              default: state_n = ST_FINISH;
            endcase
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_WREN_A;
      idx_q   <= '0;
      gap_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cmd_q   <= cmd_n;
      idx_q   <= idx_n;
      gap_q   <= gap_n;
      err_q   <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      addr_q  <= '0;
      pages_q <= '0;
    end else if (range_en) begin
      addr_q  <= addr_n;
      pages_q <= pages_n;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FINISH);
  assign err       = (state_q == ST_FINISH) && err_q;
  assign spi_cs_n  = (state_q != ST_XFER);
  assign byte_req  = (state_q == ST_XFER);
  assign byte_tx   = frame_byte;

endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int ADDR_W    = 24,
  parameter int DEV_BYTES = 1 << 20,
  parameter int PAGE_LOG2 = 12,
  parameter int CS_GAP    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] req_len,
  input logic              done,
  input logic              err,
  input logic              spi_cs_n,
  input logic              byte_req,
  input logic [7:0]        byte_tx,
  input logic              byte_done
);

  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEV_BYTES);

  logic chk_bad;
  assign chk_bad = (req_addr[PAGE_LOG2-1:0] != '0) || (req_len[PAGE_LOG2-1:0] != '0) ||
                   (req_len == '0) || (({1'b0, req_addr} + {1'b0, req_len}) > LIMIT);

  // counts select-high cycles since the last frame, saturating at CS_GAP
  logic [GAP_W-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_q <= '0;
    else if (!spi_cs_n)                  hi_q <= '0;
    else if (hi_q != GAP_W'(CS_GAP))     hi_q <= hi_q + 1'b1;
  end

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && chk_bad) |=> (done && err));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !chk_bad) |=> (!done && !req_ready));

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_q == GAP_W'(CS_GAP)));

  assert_tx_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && !byte_done) |=> (byte_req && $stable(byte_tx)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind flash_erase_seq erase_seq_chk #(
  .ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .PAGE_LOG2(PAGE_LOG2), .CS_GAP(CS_GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .done(done), .err(err),
  .spi_cs_n(spi_cs_n), .byte_req(byte_req), .byte_tx(byte_tx), .byte_done(byte_done)
);

// File: tb/sim_flash_erase_seq.sv
`timescale 1ns/1ps
module sim_flash_erase_seq;

  localparam int CS_GAP = 2;
  localparam int NV     = 10;
  localparam int LOGN   = 256;

  typedef struct packed {
    logic [23:0] addr;
    logic [23:0] len;
    logic [7:0]  busy;
    logic [15:0] limit;
  } vec_t;

  // addr, len, busy reads per erase, poll limit
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 24'h001000, 8'd2, 16'd8},
    '{24'h0FF000, 24'h001000, 8'd0, 16'd4},
    '{24'h012000, 24'h003000, 8'd1, 16'd4},
    '{24'h000800, 24'h001000, 8'd0, 16'd4},
    '{24'h001000, 24'h000800, 8'd0, 16'd4},
    '{24'h0FF000, 24'h002000, 8'd0, 16'd4},
    '{24'h000000, 24'h000000, 8'd0, 16'd4},
    '{24'h034000, 24'h002000, 8'd3, 16'd3},
    '{24'h0AB000, 24'h001000, 8'd2, 16'd3},
    '{24'hFFF000, 24'h001000, 8'd0, 16'd4}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [23:0] req_addr, req_len;
  logic [15:0] poll_limit;
  logic        done, err, spi_cs_n, byte_req;
  logic [7:0]  byte_tx;
  logic        byte_done;
  logic [7:0]  byte_rx;

  int checks = 0;
  int errors = 0;

  logic [8:0] exp_log [LOGN];
  logic [8:0] got_log [LOGN];
  int exp_n, got_n;
  logic exp_err;
  int cur_busy, busy_left;
  int min_gap, req_cs_high, long_done;

  flash_erase_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
    .done(done), .err(err), .spi_cs_n(spi_cs_n), .byte_req(byte_req),
    .byte_tx(byte_tx), .byte_done(byte_done), .byte_rx(byte_rx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired: actual 0x0 expected 0x1");
    finish_up();
  end

  // byte engine and flash responder
  initial begin
    int pos;
    logic [7:0] op, tb, rx;
    pos = 0; op = 8'h00;
    byte_done = 1'b0; byte_rx = 8'h00; busy_left = 0;
    forever begin
      @(negedge clk);
      byte_done = 1'b0;
      if (spi_cs_n) pos = 0;
      if (rst_n && byte_req) begin
        tb = byte_tx;
        if (got_n < LOGN) got_log[got_n] = {pos == 0, tb};
        got_n++;
        if (pos == 0) op = tb;
        if (pos == 0 && tb == 8'h20) busy_left = cur_busy;
        rx = 8'h00;
        if (op == 8'h05 && pos == 1) begin
          if (busy_left > 0) begin rx = 8'h03; busy_left--; end
          else rx = 8'h02;
        end
        pos++;
        repeat (2) @(negedge clk);
        byte_rx = rx;
        byte_done = 1'b1;
      end
    end
  end

  // port monitors
  initial begin
    int hi, dw;
    hi = 0; dw = 0;
    min_gap = 1000; req_cs_high = 0; long_done = 0;
    forever begin
      @(negedge clk);
      if (byte_req && spi_cs_n) req_cs_high++;
      if (spi_cs_n) hi++;
      else begin
        if (hi > 0 && hi < min_gap) min_gap = hi;
        hi = 0;
      end
      if (done) begin dw++; if (dw > 1) long_done++; end
      else dw = 0;
    end
  end

  task automatic push(input logic [8:0] e);
    if (exp_n < LOGN) exp_log[exp_n] = e;
    exp_n++;
  endtask

  task automatic push_status();
    push({1'b1, 8'h05});
    push({1'b0, 8'h00});
  endtask

  task automatic build_expected(input vec_t v);
    bit bad;
    int pages, lim;
    logic [23:0] a;
    exp_n = 0;
    bad = (v.addr[11:0] != 0) || (v.len[11:0] != 0) || (v.len == 0) ||
          ((int'(v.addr) + int'(v.len)) > 32'h0010_0000);
    if (bad) begin exp_err = 1'b1; return; end
    pages = int'(v.len) >> 12;
    lim = (v.limit == 0) ? 1 : int'(v.limit);
    a = v.addr;
    for (int p = 0; p < pages; p++) begin
      push({1'b1, 8'h06});
      push({1'b1, 8'h39}); push({1'b0, a[23:16]}); push({1'b0, a[15:8]}); push({1'b0, a[7:0]});
      push({1'b1, 8'h06});
      push({1'b1, 8'h20}); push({1'b0, a[23:16]}); push({1'b0, a[15:8]}); push({1'b0, a[7:0]});
      if (int'(v.busy) >= lim) begin
        for (int s = 0; s < lim; s++) push_status();
        push({1'b1, 8'h04});
        exp_err = 1'b1;
        return;
      end
      for (int s = 0; s <= int'(v.busy); s++) push_status();
      a = a + 24'h001000;
    end
    push({1'b1, 8'h04});
    exp_err = 1'b0;
  endtask

  task automatic run_req(input vec_t v, input string tag);
    int cnt, mis;
    build_expected(v);
    got_n = 0;
    cur_busy = int'(v.busy);
    @(negedge clk);
    poll_limit = v.limit;
    req_addr = v.addr;
    req_len = v.len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!done && cnt < 5000) begin @(negedge clk); cnt++; end
    check(done == 1'b1, "R10", {tag, " completion seen"}, done, 1);
    check(err == exp_err, exp_err ? "R2/R7" : "R6", {tag, " error flag"}, err, exp_err);
    check(spi_cs_n == 1'b1, "R10", {tag, " select high at done"}, spi_cs_n, 1);
    check(got_n == exp_n, "R3", {tag, " byte count"}, got_n, exp_n);
    mis = -1;
    for (int i = 0; i < exp_n && i < got_n && i < LOGN; i++)
      if (mis < 0 && got_log[i] != exp_log[i]) mis = i;
    check(mis < 0, "R3/R4/R5/R6", {tag, " frame stream"},
          (mis < 0) ? 0 : got_log[mis], (mis < 0) ? 0 : exp_log[mis]);
    @(negedge clk);
    check(done == 1'b0, "R10", {tag, " done single pulse"}, done, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
    poll_limit = 16'd4; got_n = 0; cur_busy = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1 && byte_req == 1'b0, "R1", "select/request in reset", {spi_cs_n, byte_req}, 2'b10);
    check(done == 1'b0 && err == 1'b0 && req_ready == 1'b1, "R1", "done/err/ready in reset",
          {done, err, req_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1 && spi_cs_n == 1'b1, "R1", "idle after release", {req_ready, spi_cs_n}, 2'b11);

    for (int k = 0; k < NV; k++) run_req(VECS[k], $sformatf("vec%0d", k));

    // R7 limit of zero behaves as one busy read
    run_req('{24'h020000, 24'h001000, 8'd1, 16'd0}, "limit0");

    // R8 select gap and R9 request only under select
    check(min_gap >= CS_GAP, "R8", "minimum select-high gap", min_gap, CS_GAP);
    check(req_cs_high == 0, "R9", "byte request with select high", req_cs_high, 0);
    check(long_done == 0, "R10", "done wider than one cycle", long_done, 0);

    // R1 reset in the middle of an erase
    cur_busy = 5; got_n = 0;
    @(negedge clk);
    poll_limit = 16'd50; req_addr = 24'h050000; req_len = 24'h002000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (30) @(negedge clk);
    check(got_n > 0, "R3", "activity before mid-run reset", got_n, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1'b1 && byte_req == 1'b0 && req_ready == 1'b1 && done == 1'b0,
          "R1", "outputs after mid-run reset", {spi_cs_n, byte_req, req_ready, done}, 4'b1010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    run_req(VECS[0], "after_reset");

    finish_up();
  end

endmodule